// File: doc/BRIEF.md
# Three-State PWM Command Decoder

This block sits behind a pair of window comparators watching a three-level PWM line. One comparator bit says the line is above the upper threshold. The other says it is below the lower threshold. When neither bit is set, the line sits in the middle band, and a floating, undriven line also settles there. The block resynchronises both bits into its own clock and turns them into one clean command for the gate-drive sequencer: drive the high side, drive the low side, or switch both off.

The middle band is only taken as a shutdown request once the line has stayed there for an unbroken hold-off period. The period is set in clock cycles by a parameter; 38 cycles at 250 MHz covers the nominal 150 ns. If the line only crosses the band on its way between the two logic levels, the decoder keeps the last valid command. Once the line is back at a valid level, the command follows it immediately, even when leaving shutdown. On each exit from shutdown the block raises a single-cycle marker, which the sequencer can use to pick its fast exit timing.

The block has no data stream, so it has no valid/ready handshake. All of its pins are plain control signals.

Top module: `pwm3_decoder`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `cmd` reads OFF and `exit_pulse` is 0.
- R2: The `cmd` encoding is 2'b00 = OFF, 2'b01 = LOW and 2'b10 = HIGH. The input pair {`cmp_above_hi`,`cmp_below_lo`} = 2'b10 is the high level, 2'b01 is the low level, and 2'b00 is the middle band.
- R3: A change to a valid level that is applied before clock edge n shows on `cmd` after edge n+SYNC_STAGES, and not earlier. This is a latency of SYNC_STAGES+1 edges.
- R4: Up to HOLD_CYCLES-1 consecutive middle-band samples leave `cmd` at its previous HIGH or LOW value, and it never reads OFF.
- R5: HOLD_CYCLES consecutive middle-band samples turn `cmd` to OFF, and it stays OFF while the band persists.
- R6: When the line leaves a qualified OFF, `cmd` takes the new level at once with no extra qualification. `exit_pulse` is high for exactly one cycle, the first non-OFF cycle. Changes directly between HIGH and LOW raise no pulse.
- R7: The hold-off timer restarts from zero each time the line re-enters the band. Two band episodes of HOLD_CYCLES-1 samples each, separated by one valid sample, do not produce OFF.
- R8: The invalid pair 2'b11 is treated exactly like the middle band. It counts toward the hold-off whether alone or mixed with 2'b00 samples.
- R9: A valid level held for a single sample reaches `cmd` for exactly one cycle, so short PWM pulses pass through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Decoder clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_above_hi | input | 1 | Asynchronous comparator bit: line above the upper threshold |
| cmp_below_lo | input | 1 | Asynchronous comparator bit: line below the lower threshold |
| cmd | output | 2 | Command: 00 OFF, 01 LOW, 10 HIGH |
| exit_pulse | output | 1 | One-cycle marker on the first cycle after leaving OFF |

## Verification
The embedded assertions check every cycle that:
- a valid decoded level reaches the command register on the next edge;
- the command is frozen while the band is present but not yet qualified;
- OFF is entered only from an expired timer;
- the exit marker coincides exactly with leaving OFF;
- the timer stays bounded and clears outside the band.

Some behaviour can only be shown by the bench's scenarios, because it spans the comparator inputs and the synchroniser:
- the exact end-to-end latency;
- the HOLD_CYCLES-1 versus HOLD_CYCLES boundary;
- the timer restart across a one-sample interruption;
- the handling of the 11 code;
- the passage of single-sample pulses.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

  typedef enum logic [1:0] {
    CMD_OFF  = 2'b00,
    CMD_LOW  = 2'b01,
    CMD_HIGH = 2'b10
  } pwm_cmd_e;

  typedef enum logic [1:0] {
    LVL_MID  = 2'b00,
    LVL_LOW  = 2'b01,
    LVL_HIGH = 2'b10
  } pwm_lvl_e;

  // R2, R8: only a clean one-hot pair is a logic level; 00 and 11 fall in the band
  function automatic pwm_lvl_e classify(input logic above_hi, input logic below_lo);
    if (above_hi && !below_lo)      return LVL_HIGH;
    else if (below_lo && !above_hi) return LVL_LOW;
    else                            return LVL_MID;
  endfunction

endpackage

// File: rtl/pwm3_sync.sv
module pwm3_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/pwm3_holdoff.sv
module pwm3_holdoff #(
  parameter int HOLD_CYCLES = 38
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_band,
  output logic expired
);

  localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(HOLD_CYCLES - 1);

  // number of earlier consecutive band cycles, saturating at LAST_C
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!in_band)       cnt <= '0;
    else if (cnt != LAST_C)  cnt <= cnt + 1'b1;
  end

  // the current band cycle is the HOLD_CYCLES-th in a row
  assign expired = in_band && (cnt == LAST_C);

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST_C);

  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_band |=> (cnt == '0));

  p_sat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_band && cnt == LAST_C) |=> (cnt == LAST_C));

endmodule

// File: rtl/pwm3_cmd_fsm.sv
module pwm3_cmd_fsm
  import pwm3_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pwm_lvl_e lvl,
  input  logic     expired,
  output pwm_cmd_e cmd,
  output logic     exit_pulse
);

  pwm_cmd_e nxt;

  always_comb begin
    unique case (lvl)
      LVL_HIGH: nxt = CMD_HIGH;
      LVL_LOW:  nxt = CMD_LOW;
      default:  nxt = expired ? CMD_OFF : cmd;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd        <= CMD_OFF;
      exit_pulse <= 1'b0;
    end else begin
      cmd        <= nxt;
      exit_pulse <= (cmd == CMD_OFF) && (nxt != CMD_OFF);
    end
  end

  p_follow_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == LVL_HIGH) |=> (cmd == CMD_HIGH));

  p_follow_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == LVL_LOW) |=> (cmd == CMD_LOW));

  p_keep_in_band_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == LVL_MID && !expired) |=> $stable(cmd));

  p_off_needs_timer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_OFF && $past(cmd) != CMD_OFF) |-> $past(expired));

  p_exit_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exit_pulse |-> ($past(cmd) == CMD_OFF && cmd != CMD_OFF));

  p_exit_needed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != CMD_OFF && $past(cmd) == CMD_OFF) |-> exit_pulse);

endmodule

// File: rtl/pwm3_decoder.sv
module pwm3_decoder
  import pwm3_pkg::*;
#(
  parameter int HOLD_CYCLES = 38,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp_above_hi,
  input  logic       cmp_below_lo,
  output logic [1:0] cmd,
  output logic       exit_pulse
);

  logic [1:0] cmp_sync;
  pwm_lvl_e   lvl;
  logic       expired;
  pwm_cmd_e   cmd_e;

  pwm3_sync #(
    .STAGES(SYNC_STAGES),
    .WIDTH (2)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({cmp_above_hi, cmp_below_lo}),
    .q    (cmp_sync)
  );

  assign lvl = classify(cmp_sync[1], cmp_sync[0]);

  pwm3_holdoff #(
    .HOLD_CYCLES(HOLD_CYCLES)
  ) u_holdoff (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_band(lvl == LVL_MID),
    .expired(expired)
  );

  pwm3_cmd_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl       (lvl),
    .expired   (expired),
    .cmd       (cmd_e),
    .exit_pulse(exit_pulse)
  );

  assign cmd = cmd_e;

  p_legal_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd != 2'b11);

endmodule

// File: tb/pwm3_decoder_bench.sv
module pwm3_decoder_bench;

  localparam int HOLD = 38;
  localparam int SYNC = 2;
  localparam logic [1:0] C_OFF = 2'b00, C_LOW = 2'b01, C_HIGH = 2'b10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_above_hi = 1'b0;
  logic       cmp_below_lo = 1'b0;
  logic [1:0] cmd;
  logic       exit_pulse;

  int checks = 0;
  int errors = 0;
  int n_off = 0, n_low = 0, n_exit = 0, n_bad_exit = 0;

  always #2 clk = ~clk;

  pwm3_decoder #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(SYNC)) u_pwm3_decoder (
    .clk(clk), .rst_n(rst_n),
    .cmp_above_hi(cmp_above_hi), .cmp_below_lo(cmp_below_lo),
    .cmd(cmd), .exit_pulse(exit_pulse)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      n_off      <= n_off + int'(cmd == C_OFF);
      n_low      <= n_low + int'(cmd == C_LOW);
      n_exit     <= n_exit + int'(exit_pulse);
      n_bad_exit <= n_bad_exit + int'(exit_pulse && cmd == C_OFF);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // apply a code for n samples; starts and ends at a negedge
  task automatic put(input logic hi, input logic lo, input int n);
    cmp_above_hi = hi;
    cmp_below_lo = lo;
    repeat (n) @(negedge clk);
  endtask

  // {hi, lo, expected cmd, length}
  localparam int NV = 9;
  localparam logic [11:0] VEC [NV] = '{
    {1'b1, 1'b0, 2'b10, 8'd10},
    {1'b0, 1'b1, 2'b01, 8'd10},
    {1'b0, 1'b0, 2'b00, 8'd60},
    {1'b1, 1'b0, 2'b10, 8'd10},
    {1'b1, 1'b1, 2'b00, 8'd60},
    {1'b0, 1'b1, 2'b01, 8'd10},
    {1'b1, 1'b0, 2'b10, 8'd5},
    {1'b0, 1'b0, 2'b00, 8'd60},
    {1'b0, 1'b1, 2'b01, 8'd10}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int o0, e0, l0;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 cmd in reset", int'(cmd), int'(C_OFF));
    chk("R1 pulse in reset", int'(exit_pulse), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cmd after release", int'(cmd), int'(C_OFF));
    chk("R1 pulse after release", int'(exit_pulse), 0);

    // table walk: R2 encodings, R5 long band, R8 code 11
    for (int i = 0; i < NV; i++) begin
      put(VEC[i][11], VEC[i][10], int'(VEC[i][7:0]));
      chk("R2/R5/R8 table step", int'(cmd), int'(VEC[i][9:8]));
    end

    // R3 latency from LOW to HIGH
    put(1'b0, 1'b1, 10);
    cmp_above_hi = 1'b1; cmp_below_lo = 1'b0;
    repeat (SYNC) @(negedge clk);
    chk("R3 not early", int'(cmd), int'(C_LOW));
    @(negedge clk);
    chk("R3 on time", int'(cmd), int'(C_HIGH));
    put(1'b1, 1'b0, 10);

    // R4 short band crossing keeps HIGH
    o0 = n_off;
    put(1'b0, 1'b0, HOLD - 1);
    put(1'b1, 1'b0, 10);
    chk("R4 no OFF on short band", n_off - o0, 0);
    chk("R4 kept HIGH", int'(cmd), int'(C_HIGH));

    // R5 exact hold-off, then LOW: OFF for one cycle, one exit pulse
    o0 = n_off; e0 = n_exit;
    put(1'b0, 1'b0, HOLD);
    put(1'b0, 1'b1, 10);
    chk("R5 OFF cycles at boundary", n_off - o0, 1);
    chk("R6 one exit pulse", n_exit - e0, 1);
    chk("R6 follows LOW", int'(cmd), int'(C_LOW));

    // R6 exit from long OFF to HIGH
    o0 = n_off; e0 = n_exit;
    put(1'b0, 1'b0, 60);
    chk("R5 stays OFF", int'(cmd), int'(C_OFF));
    put(1'b1, 1'b0, 10);
    chk("R6 exit to HIGH pulse", n_exit - e0, 1);
    chk("R6 pulse never during OFF", n_bad_exit, 0);
    chk("R6 follows HIGH", int'(cmd), int'(C_HIGH));

    // R6 no pulse on direct HIGH/LOW toggles
    e0 = n_exit;
    for (int k = 0; k < 6; k++) put(k[0], ~k[0], 4);
    put(1'b1, 1'b0, 10);
    chk("R6 no pulse on toggles", n_exit - e0, 0);

    // R7 restart after a one-sample interruption
    o0 = n_off;
    put(1'b0, 1'b0, HOLD - 1);
    put(1'b1, 1'b0, 1);
    put(1'b0, 1'b0, HOLD - 1);
    put(1'b1, 1'b0, 10);
    chk("R7 no OFF after restart", n_off - o0, 0);

    // R8 mix of 11 and 00 counts as band
    o0 = n_off;
    put(1'b1, 1'b1, HOLD - 1);
    put(1'b1, 1'b0, 10);
    chk("R8 short 11 keeps HIGH", n_off - o0, 0);
    o0 = n_off;
    put(1'b1, 1'b1, HOLD / 2);
    put(1'b0, 1'b0, HOLD - HOLD / 2);
    put(1'b0, 1'b1, 10);
    chk("R8 mixed band qualifies", n_off - o0, 1);

    // R9 single-sample LOW pulse between HIGHs
    put(1'b1, 1'b0, 10);
    l0 = n_low;
    put(1'b0, 1'b1, 1);
    put(1'b1, 1'b0, 10);
    chk("R9 one-cycle LOW", n_low - l0, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule